// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit data pointers and a small control register that picks which one is active. The active pointer drives the external data address. A CPU core reaches the control register and the active pointer's two bytes over a simple byte-wide special-function-register bus. Two dedicated strobes load the active pointer with a 16-bit immediate or add one to it.

The control register carries the pointer select in bit 0, a general-purpose flag in bit 3 and a boot-memory enable in bit 5. Bit 2 is tied to zero. Because of this, a read-modify-write increment of the whole register flips only the select bit. Software can therefore swap pointers with a single increment and leave the flag bits alone.

The select bit is a two-state machine. In state `SEL_PTR0`, pointer 0 is active. In state `SEL_PTR1`, pointer 1 is active. Every write to the control register makes one transition, chosen by write-data bit 0:
- `T_TO_P0` (bit 0 = 0) leads to `SEL_PTR0`.
- `T_TO_P1` (bit 0 = 1) leads to `SEL_PTR1`.

If no control write occurs, the machine holds its state. Reset places it in `SEL_PTR0`.

Top module: `dptr_pair`

## Requirements
- R1: The control register sits at address A2h and is accessed only as a whole byte. A read returns the select in bit 0, the flag in bit 3 and the boot enable in bit 5. Bits 1, 4, 6 and 7 read 0 and discard writes.
- R2: With select 0, `ext_addr` shows pointer 0. With select 1, it shows pointer 1.
- R3: Bit 2 of the control register always reads 0 and ignores writes. Writing back the read value plus one therefore flips bit 0 only and leaves bits 3 and 5 unchanged.
- R4: Bit 3 holds the last value written to it and has no effect on any output other than its own read-back.
- R5: `boot_map` equals control bit 5, one cycle after the write that sets or clears it.
- R6: A load or an increment changes only the active pointer. The inactive pointer keeps its value.
- R7: After reset, both pointers are 0000h and every control bit is 0. As a result, pointer 0 is active, `ext_addr` is 0000h and `boot_map` is 0.
- R8: An increment adds one to the active pointer in a single clock and wraps from FFFFh to 0000h.
- R9: A byte write to 82h replaces the active pointer's low byte, and a byte write to 83h replaces its high byte. Reads of 82h and 83h return the active pointer's low and high bytes. Reads of any other address return 00h.
- R10: A pointer operation in the same cycle as a control write uses the select value from before that write. Among pointer operations in one cycle, load beats increment, and increment beats a byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` (combinational) |
| ld_en | input | 1 | Load active pointer with `ld_val` |
| ld_val | input | 16 | Immediate pointer value |
| inc_en | input | 1 | Increment the active pointer |
| ext_addr | output | 16 | Active pointer, used as external data address |
| boot_map | output | 1 | Boot memory maps F800h-FFFFh when high |

## Verification
On every cycle, the assertions check several properties:
- the zero bits of the control read-back;
- `boot_map` following a control write;
- the inactive pointer staying stable during a load or increment;
- the single-cycle wrapping increment;
- a load landing in the pointer chosen by the previous select when a control write happens in the same cycle.

Only the bench scenarios can show the remaining behaviour: the reset values, the increment-to-swap sequence keeping the flag and boot bits, the byte writes to the pointer halves, and the priority among strobes. The bench compares these against its own model during random traffic and directed corner cases.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned PTR_W    = 2 * BYTE_W;
    localparam int unsigned NUM_PTR  = 2;
    localparam int unsigned SEL_W    = $clog2(NUM_PTR);

    localparam logic [BYTE_W-1:0] ADDR_CTRL = 8'hA2;
    localparam logic [BYTE_W-1:0] ADDR_PLO  = 8'h82;
    localparam logic [BYTE_W-1:0] ADDR_PHI  = 8'h83;

    localparam int unsigned SEL_BIT  = 0;
    localparam int unsigned FLAG_BIT = 3;
    localparam int unsigned BOOT_BIT = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_PTR0 = 1'b0,
        SEL_PTR1 = 1'b1
    } sel_state_e;
endpackage

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output sel_state_e        sel,
    output logic              flag,
    output logic              boot,
    output logic [BYTE_W-1:0] ctrl_rd
);
    sel_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_PTR0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_PTR0: if (ctrl_wr && wdata[SEL_BIT])  state_d = SEL_PTR1; // T_TO_P1
            SEL_PTR1: if (ctrl_wr && !wdata[SEL_BIT]) state_d = SEL_PTR0; // T_TO_P0
            default:  state_d = SEL_PTR0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            boot <= 1'b0;
        end else if (ctrl_wr) begin
            flag <= wdata[FLAG_BIT];
            boot <= wdata[BOOT_BIT];
        end
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[SEL_BIT]  = (state_q == SEL_PTR1);
        ctrl_rd[FLAG_BIT] = flag;
        ctrl_rd[BOOT_BIT] = boot;
    end

    assign sel = state_q;
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
    parameter int unsigned DW    = 8,
    parameter int unsigned NPTR  = 2,
    localparam int unsigned AW   = 2 * DW,
    localparam int unsigned SW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_val,
    input  logic             inc_en,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wdata,
    output logic [NPTR*AW-1:0] ptr_flat,
    output logic [AW-1:0]    active
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [AW-1:0] q;
        logic          hit;
        assign hit = (sel == SW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= '0;
            else if (hit) begin
                if (ld_en)       q <= ld_val;
                else if (inc_en) q <= q + AW'(1);
                else if (wr_lo)  q[DW-1:0] <= wdata;
                else if (wr_hi)  q[AW-1:DW] <= wdata;
            end
        end

        assign ptr_flat[g*AW +: AW] = q;
    end

    always_comb begin
        active = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (sel == SW'(i)) active = ptr_flat[i*AW +: AW];
        end
    end
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              ld_en,
    input  logic [15:0]       ld_val,
    input  logic              inc_en,
    output logic [15:0]       ext_addr,
    output logic              boot_map
);
    sel_state_e              sel_s;
    logic                    flag_s;
    logic [BYTE_W-1:0]       ctrl_rd;
    logic [NUM_PTR*PTR_W-1:0] ptr_flat;
    logic [PTR_W-1:0]        act_ptr;
    logic                    ctrl_wr, wr_lo, wr_hi;

    assign ctrl_wr = sfr_wr && (sfr_addr == ADDR_CTRL);
    assign wr_lo   = sfr_wr && (sfr_addr == ADDR_PLO);
    assign wr_hi   = sfr_wr && (sfr_addr == ADDR_PHI);

    dptr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (sfr_wdata),
        .sel     (sel_s),
        .flag    (flag_s),
        .boot    (boot_map),
        .ctrl_rd (ctrl_rd)
    );

    dptr_bank #(.DW(BYTE_W), .NPTR(NUM_PTR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_s),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .inc_en   (inc_en),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (sfr_wdata),
        .ptr_flat (ptr_flat),
        .active   (act_ptr)
    );

    always_comb begin
        case (sfr_addr)
            ADDR_CTRL: sfr_rdata = ctrl_rd;
            ADDR_PLO:  sfr_rdata = act_ptr[BYTE_W-1:0];
            ADDR_PHI:  sfr_rdata = act_ptr[PTR_W-1:BYTE_W];
            default:   sfr_rdata = '0;
        endcase
    end

    assign ext_addr = act_ptr;
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk
    import dptr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sfr_addr,
    input logic        sfr_wr,
    input logic [7:0]  sfr_wdata,
    input logic [7:0]  sfr_rdata,
    input logic        ld_en,
    input logic [15:0] ld_val,
    input logic        inc_en,
    input logic [15:0] ext_addr,
    input logic        boot_map,
    input sel_state_e  sel,
    input logic [15:0] ptr0,
    input logic [15:0] ptr1
);
    logic cw;
    assign cw = sfr_wr && (sfr_addr == ADDR_CTRL);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CTRL) |-> ((sfr_rdata & 8'hD2) == 8'h00));

    p_bit2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CTRL) |-> !sfr_rdata[2]);

    p_boot_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (boot_map == $past(sfr_wdata[BOOT_BIT])));

    p_hold_p1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_en || inc_en) && sel == SEL_PTR0) |=> $stable(ptr1));

    p_hold_p0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_en || inc_en) && sel == SEL_PTR1) |=> $stable(ptr0));

    p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !ld_en && !cw) |=> (ext_addr == $past(ext_addr) + 16'd1));

    p_old_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && cw) |=>
        ((($past(sel) == SEL_PTR1) ? ptr1 : ptr0) == $past(ld_val)));
endmodule

bind dptr_pair dptr_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .inc_en    (inc_en),
    .ext_addr  (ext_addr),
    .boot_map  (boot_map),
    .sel       (sel_s),
    .ptr0      (ptr_flat[15:0]),
    .ptr1      (ptr_flat[31:16])
);

// File: tb/test_dptr_pair.sv
`timescale 1ns/1ps
module test_dptr_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = '0;
    logic        inc_en = 1'b0;
    logic [15:0] ext_addr;
    logic        boot_map;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] m_ptr [2];
    bit          m_sel, m_flag, m_boot;

    always #2.5 clk = ~clk;

    dptr_pair i_dptr_pair (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ld_en(ld_en),
        .ld_val(ld_val), .inc_en(inc_en), .ext_addr(ext_addr), .boot_map(boot_map)
    );

    function automatic logic [7:0] model_rd(logic [7:0] a);
        logic [15:0] p;
        p = m_ptr[m_sel];
        case (a)
            8'hA2:   return {2'b00, m_boot, 1'b0, m_flag, 2'b00, m_sel};
            8'h82:   return p[7:0];
            8'h83:   return p[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update(logic [7:0] a, bit w, logic [7:0] d,
                                bit ld, logic [15:0] lv, bit inc);
        bit s;
        s = m_sel;
        if (ld)                    m_ptr[s] = lv;
        else if (inc)              m_ptr[s] = m_ptr[s] + 16'd1;
        else if (w && a == 8'h82)  m_ptr[s][7:0]  = d;
        else if (w && a == 8'h83)  m_ptr[s][15:8] = d;
        if (w && a == 8'hA2) begin
            m_sel  = d[0];
            m_flag = d[3];
            m_boot = d[5];
        end
    endtask

    // called just after a falling edge
    task automatic step(logic [7:0] a, bit w, logic [7:0] d,
                        bit ld, logic [15:0] lv, bit inc, string tag);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d;
        ld_en = ld; ld_val = lv; inc_en = inc;
        #0.5;
        chk({tag, " rdata"}, {24'b0, sfr_rdata}, {24'b0, model_rd(a)});
        @(posedge clk);
        model_update(a, w, d, ld, lv, inc);
        @(negedge clk);
        sfr_wr = 1'b0; ld_en = 1'b0; inc_en = 1'b0;
        chk({tag, " ext_addr"}, {16'b0, ext_addr}, {16'b0, m_ptr[m_sel]});
        chk({tag, " boot_map"}, {31'b0, boot_map}, {31'b0, m_boot});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        m_ptr[0] = '0; m_ptr[1] = '0; m_sel = 0; m_flag = 0; m_boot = 0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        chk("R7 ext_addr", {16'b0, ext_addr}, 32'h0);
        chk("R7 boot_map", {31'b0, boot_map}, 32'h0);
        sfr_addr = 8'hA2; #0.5;
        chk("R7 ctrl", {24'b0, sfr_rdata}, 32'h0);
        @(negedge clk);

        // R1 R3 R5: all ones written, only defined bits stick
        step(8'hA2, 1, 8'hFF, 0, 16'h0, 0, "R5");
        sfr_addr = 8'hA2; #0.5;
        chk("R1 R3 readback", {24'b0, sfr_rdata}, 32'h29);
        @(negedge clk);

        // R8 wrap on pointer 1
        step(8'h00, 0, 8'h00, 1, 16'hFFFF, 0, "R6");
        step(8'h00, 0, 8'h00, 0, 16'h0, 1, "R8");
        chk("R8 wrap", {16'b0, ext_addr}, 32'h0);

        // R2 R6: pointer 0 load, pointer 1 untouched
        step(8'hA2, 1, 8'h28, 0, 16'h0, 0, "R2");
        step(8'h00, 0, 8'h00, 1, 16'h1234, 0, "R6");
        chk("R2 ptr0", {16'b0, ext_addr}, 32'h1234);

        // R3 R4: read-modify-write increment toggles select only
        sfr_addr = 8'hA2; #0.5; rv = sfr_rdata; @(negedge clk);
        step(8'hA2, 1, rv + 8'd1, 0, 16'h0, 0, "R3");
        chk("R3 toggled to ptr1", {16'b0, ext_addr}, 32'h0);
        sfr_addr = 8'hA2; #0.5; rv = sfr_rdata;
        chk("R4 flag kept", {31'b0, rv[3]}, 32'h1);
        @(negedge clk);
        step(8'hA2, 1, rv + 8'd1, 0, 16'h0, 0, "R3");
        chk("R3 back to ptr0", {16'b0, ext_addr}, 32'h1234);

        // R9 byte writes
        step(8'h82, 1, 8'hCD, 0, 16'h0, 0, "R9");
        step(8'h83, 1, 8'hAB, 0, 16'h0, 0, "R9");
        chk("R9 bytes", {16'b0, ext_addr}, 32'hABCD);

        // R10 load with select change uses old select; load beats inc/byte write
        step(8'hA2, 1, 8'h01, 1, 16'h5A5A, 0, "R10");
        chk("R10 ptr1 untouched", {16'b0, ext_addr}, 32'h0);
        step(8'h82, 1, 8'h77, 1, 16'h0F0F, 1, "R10");
        chk("R10 priority", {16'b0, ext_addr}, 32'h0F0F);
        step(8'h83, 1, 8'h11, 0, 16'h0, 1, "R10");
        chk("R10 inc over byte", {16'b0, ext_addr}, 32'h0F10);

        // random traffic: R2 R4 R6 R8 R9 R10
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            int k;
            k = $urandom_range(0, 9);
            if (k < 2)      a = 8'hA2;
            else if (k < 5) a = 8'h82;
            else if (k < 8) a = 8'h83;
            else            a = 8'($urandom);
            step(a, ($urandom_range(0, 2) == 0), 8'($urandom),
                 ($urandom_range(0, 4) == 0), 16'($urandom),
                 ($urandom_range(0, 2) == 0), "R2/R4/R6/R8/R9/R10 random");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule